// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines into a single processor IRQ and gives the handler a ready-made handler address. Each request line is sampled once per clock. A per-source enable mask gates it. The block then compares it against a bank of prioritised vector slots. Every slot can be bound to one source and carries a programmable handler address. Slot 0 has the highest priority and the last slot the lowest.

Software reaches the block through a simple synchronous register bus. At handler entry, a read of the vector-address register returns the address of the winning slot. The same read raises the in-service level, so that only sources bound to strictly higher-priority slots can assert the IRQ again. The served level is held on a small nesting stack. A write of any value to the vector-address register marks end of service, pops the stack and restores the previous level. If no slot matches, the read returns a default address, and non-vectored sources stay blocked until the matching end-of-service write.

Every bus request is accepted in the cycle it is presented. There is no back-pressure. Write data lands on the next clock edge. Read data and its valid strobe appear one cycle after the request.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `rd_valid` is low.
- R2: A write to the enable register (offset 0x02) ORs the written ones into the enable mask; written zeros leave their bits unchanged; a read of 0x02 returns the mask.
- R3: A write to the enable-clear register (offset 0x03) clears each enable bit written as one, so writing all ones disables every source; 0x03 reads as zero.
- R4: Offset 0x01 returns the request lines as sampled one clock earlier, and offset 0x06 returns those sampled lines ANDed with the enable mask.
- R5: Slot addresses live at 0x40+n and slot controls at 0x60+n; in a control word bit 5 enables the slot and bits 4:0 name the bound source; both read back as written (control zero-extended from 6 bits); the default address lives at 0x05.
- R6: A read of the vector-address register (offset 0x04) returns the address of the lowest-numbered enabled slot whose bound source is sampled high and enabled, among slots numbered below the current level; a higher-numbered slot bound to the same source never wins.
- R7: When no slot qualifies, the vector-address read returns the default address and records the level just below all slots (the slot count), which blocks non-vectored sources while leaving every slot eligible.
- R8: After a vector-address read that selects slot n, only sources bound to enabled slots 0..n-1 can assert `irq` or win a later read.
- R9: A write of any value to offset 0x04 pops the nesting stack and restores the previous level; with the stack empty it has no effect; when the stack holds its full depth a further read does not push.
- R10: `irq` is high exactly when some enabled, sampled-high source is permitted by the current level; with no level in service every enabled source is permitted; offset 0x00 returns this permitted pending set.
- R11: A read request yields `rd_valid` high with the data one cycle later for exactly one cycle; a write request never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Level-sensitive request lines |
| req_valid | input | 1 | Bus request strobe, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register word offset |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Processor interrupt request |

## Verification
The bench builds the block with its defaults: 32 sources, 16 slots, 32-bit data and a nesting depth of 17. With these values the full 5-bit source field and the lowest slot 15 can be reached. Deep nesting can also follow the ordering from low to high priority. A directed sequence checks the case where slot 2 and slot 3 are both bound to source 1, so a read that returns the neighbouring slot's address would be caught. Seeded random register traffic, request patterns, vector reads and end-of-service writes are then checked against a model that the bench computes itself.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [7:0] OFF_PEND    = 8'h00;
  localparam logic [7:0] OFF_RAW     = 8'h01;
  localparam logic [7:0] OFF_ENA     = 8'h02;
  localparam logic [7:0] OFF_ENA_CLR = 8'h03;
  localparam logic [7:0] OFF_VECT    = 8'h04;
  localparam logic [7:0] OFF_DFLT    = 8'h05;
  localparam logic [7:0] OFF_MASKED  = 8'h06;
  localparam logic [2:0] PAGE_SLOT_ADR = 3'b010;
  localparam logic [2:0] PAGE_SLOT_CTL = 3'b011;
endpackage

// File: rtl/vic_prio_mask.sv
module vic_prio_mask #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = $clog2(NUM_SRC),
  parameter int LVL_W     = $clog2(NUM_SLOTS + 2)
) (
  input  logic [NUM_SLOTS-1:0]            slot_en,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src,
  input  logic                            nest_empty,
  input  logic [LVL_W-1:0]                level,
  output logic [NUM_SRC-1:0]              allowed
);
  logic [NUM_SLOTS-1:0][NUM_SRC-1:0] slot_bit;
  logic [NUM_SLOTS-1:0][NUM_SRC-1:0] cum;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bit
    assign slot_bit[g] = slot_en[g] ? (NUM_SRC'(1) << slot_src[g]) : '0;
  end

  // running OR: cum[i] covers slots 0..i inclusive
  always_comb begin
    cum[0] = slot_bit[0];
    for (int i = 1; i < NUM_SLOTS; i++) cum[i] = cum[i-1] | slot_bit[i];
  end

  always_comb begin
    allowed = '0;
    if (nest_empty) begin
      allowed = '1;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (LVL_W'(i + 1) == level) allowed = cum[i];
    end
  end
endmodule

// File: rtl/vic_slot_arb.sv
module vic_slot_arb #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = $clog2(NUM_SRC),
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int LVL_W     = $clog2(NUM_SLOTS + 2)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SLOTS-1:0]            slot_en,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src,
  input  logic [NUM_SRC-1:0]              masked,
  input  logic [LVL_W-1:0]                limit,
  output logic                            hit,
  output logic [SLOT_W-1:0]               idx
);
  logic [NUM_SLOTS-1:0] cand;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cand
    assign cand[g] = slot_en[g] && masked[slot_src[g]] && (LVL_W'(g) < limit);
  end

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit = 1'b1;
        idx = SLOT_W'(i);
      end
    end
  end

  // R6: a granted slot is enabled and its bound source is pending
  a_r6_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (slot_en[idx] && masked[slot_src[idx]]));
  // R8: a granted slot lies above the in-service level
  a_r8_grant_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (LVL_W'(idx) < limit));
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int DEPTH = 17,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] top,
  output logic             empty,
  output logic             full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][LVL_W-1:0] mem_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [CNT_W-1:0]            top_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = cnt_q - CNT_W'(1);

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!empty && top_idx == CNT_W'(i)) top = mem_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mem_q <= '0;
    end else if (push && !full) begin
      for (int i = 0; i < DEPTH; i++)
        if (cnt_q == CNT_W'(i)) mem_q[i] <= push_lvl;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r9_push_records: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (!empty && top == $past(push_lvl)));
  a_r9_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> $stable(cnt_q));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_SRC    = 32,
  parameter int NUM_SLOTS  = 16,
  parameter int DATA_W     = 32,
  parameter int NEST_DEPTH = NUM_SLOTS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [7:0]         req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq
);
  import vic_pkg::*;

  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int LVL_W  = $clog2(NUM_SLOTS + 2);

  logic [NUM_SRC-1:0]              raw_q, en_q, masked, allowed, pend;
  logic [DATA_W-1:0]               dflt_q;
  logic [NUM_SLOTS-1:0]            slot_en_q;
  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src_q;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_vec_q;

  logic              acc_wr, acc_rd, vect_rd, vect_wr;
  logic              pg_adr, pg_ctl;
  logic [4:0]        slot_sel;
  logic              arb_hit;
  logic [SLOT_W-1:0] arb_idx;
  logic [LVL_W-1:0]  nest_top, limit, push_lvl;
  logic              nest_empty, nest_full;
  logic [DATA_W-1:0] vect_val, slot_rd, rd_mux;

  assign acc_wr   = req_valid && req_write;
  assign acc_rd   = req_valid && !req_write;
  assign vect_rd  = acc_rd && (req_addr == OFF_VECT);
  assign vect_wr  = acc_wr && (req_addr == OFF_VECT);
  assign pg_adr   = (req_addr[7:5] == PAGE_SLOT_ADR);
  assign pg_ctl   = (req_addr[7:5] == PAGE_SLOT_CTL);
  assign slot_sel = req_addr[4:0];

  assign masked = raw_q & en_q;
  assign pend   = masked & allowed;
  assign irq    = |pend;
  assign limit  = nest_empty ? LVL_W'(NUM_SLOTS + 1) : nest_top;

  vic_prio_mask #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_prio (
    .slot_en(slot_en_q), .slot_src(slot_src_q), .nest_empty(nest_empty),
    .level(nest_top), .allowed(allowed));

  vic_slot_arb #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W),
                 .SLOT_W(SLOT_W), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en_q), .slot_src(slot_src_q),
    .masked(masked), .limit(limit), .hit(arb_hit), .idx(arb_idx));

  assign push_lvl = arb_hit ? LVL_W'(arb_idx) : LVL_W'(NUM_SLOTS);

  vic_nest_stack #(.DEPTH(NEST_DEPTH), .LVL_W(LVL_W)) u_nest (
    .clk(clk), .rst_n(rst_n), .push(vect_rd), .push_lvl(push_lvl), .pop(vect_wr),
    .top(nest_top), .empty(nest_empty), .full(nest_full));

  always_comb begin
    vect_val = dflt_q;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (arb_hit && arb_idx == SLOT_W'(i)) vect_val = slot_vec_q[i];
  end

  always_comb begin
    slot_rd = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_sel == 5'(i)) begin
        if (pg_adr) slot_rd = slot_vec_q[i];
        if (pg_ctl) slot_rd = DATA_W'({slot_en_q[i], slot_src_q[i]});
      end
    end
  end

  always_comb begin
    case (req_addr)
      OFF_PEND:   rd_mux = DATA_W'(pend);
      OFF_RAW:    rd_mux = DATA_W'(raw_q);
      OFF_ENA:    rd_mux = DATA_W'(en_q);
      OFF_VECT:   rd_mux = vect_val;
      OFF_DFLT:   rd_mux = dflt_q;
      OFF_MASKED: rd_mux = DATA_W'(masked);
      default:    rd_mux = slot_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q      <= '0;
      en_q       <= '0;
      dflt_q     <= '0;
      slot_en_q  <= '0;
      slot_src_q <= '0;
      slot_vec_q <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      raw_q    <= irq_src;
      rd_valid <= acc_rd;
      rd_data  <= acc_rd ? rd_mux : '0;
      if (acc_wr) begin
        case (req_addr)
          OFF_ENA:     en_q   <= en_q | req_wdata[NUM_SRC-1:0];
          OFF_ENA_CLR: en_q   <= en_q & ~req_wdata[NUM_SRC-1:0];
          OFF_DFLT:    dflt_q <= req_wdata;
          default: ;
        endcase
        for (int i = 0; i < NUM_SLOTS; i++) begin
          if (slot_sel == 5'(i) && pg_adr) slot_vec_q[i] <= req_wdata;
          if (slot_sel == 5'(i) && pg_ctl) begin
            slot_en_q[i]  <= req_wdata[SRC_W];
            slot_src_q[i] <= req_wdata[SRC_W-1:0];
          end
        end
      end
    end
  end

  a_r11_rd_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_rd));
  a_r2_set_bits_land: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_addr == OFF_ENA) |=>
      ((en_q & $past(req_wdata[NUM_SRC-1:0])) == $past(req_wdata[NUM_SRC-1:0])));
  a_r3_clear_bits_land: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && req_addr == OFF_ENA_CLR) |=> ((en_q & $past(req_wdata[NUM_SRC-1:0])) == '0));
  a_r10_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(raw_q & en_q));
  a_r8_top_level_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_empty && nest_top == '0) |-> !irq);
  a_r7_default_level_push: assert property (@(posedge clk) disable iff (!rst_n)
    (vect_rd && !arb_hit && !nest_full) |=> (!nest_empty && nest_top == LVL_W'(NUM_SLOTS)));
endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
  localparam int NSRC = 32, NS = 16, DW = 32, DEPTH = NS + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] irq_src = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rd_valid, irq;
  logic [DW-1:0] rd_data;

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;

  // bench model
  logic [NSRC-1:0] m_en = '0, m_raw = '0;
  logic [DW-1:0]   m_dflt = '0;
  logic [5:0]      m_ctl [NS];
  logic [DW-1:0]   m_adr [NS];
  int              m_stk [DEPTH];
  int              m_cnt = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(NSRC), .NUM_SLOTS(NS), .DATA_W(DW), .NEST_DEPTH(DEPTH)) u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq));

  function automatic logic [NSRC-1:0] m_allowed();
    logic [NSRC-1:0] a = '0;
    if (m_cnt == 0) return '1;
    for (int i = 0; i < NS; i++)
      if (i < m_stk[m_cnt-1] && m_ctl[i][5]) a[m_ctl[i][4:0]] = 1'b1;
    return a;
  endfunction

  function automatic logic m_irq();
    return |(m_raw & m_en & m_allowed());
  endfunction

  // returns winning level (NS for default) and the address
  function automatic int m_win(output logic [DW-1:0] adr);
    int lim = (m_cnt == 0) ? NS + 1 : m_stk[m_cnt-1];
    logic [NSRC-1:0] mk = m_raw & m_en;
    for (int i = 0; i < NS; i++) begin
      if (i < lim && m_ctl[i][5] && mk[m_ctl[i][4:0]]) begin
        adr = m_adr[i];
        return i;
      end
    end
    adr = m_dflt;
    return NS;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    case (a)
      8'h02: m_en = m_en | d;
      8'h03: m_en = m_en & ~d;
      8'h04: if (m_cnt > 0) m_cnt--;
      8'h05: m_dflt = d;
      default: begin
        if (a[7:5] == 3'b010 && a[4:0] < NS) m_adr[a[4:0]] = d;
        if (a[7:5] == 3'b011 && a[4:0] < NS) m_ctl[a[4:0]] = d[5:0];
      end
    endcase
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    req_valid = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [DW-1:0] exp);
    logic [DW-1:0] d; logic v;
    bus_rd(a, d, v);
    check("R11 rd_valid", DW'(v), 1);
    check(req, d, exp);
  endtask

  task automatic vect_read(string req);
    logic [DW-1:0] ea, d; logic v; int lvl;
    lvl = m_win(ea);
    bus_rd(8'h04, d, v);
    check(req, d, ea);
    if (m_cnt < DEPTH) begin m_stk[m_cnt] = lvl; m_cnt++; end
  endtask

  task automatic set_src(logic [NSRC-1:0] v);
    @(negedge clk); irq_src = v;
    @(negedge clk); m_raw = v;
  endtask

  task automatic irq_check(string req);
    check(req, DW'(irq), DW'(m_irq()));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d; logic v; int seed;
    for (int i = 0; i < NS; i++) begin m_ctl[i] = '0; m_adr[i] = '0; end
    seed = $urandom(32'd20240607);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", DW'(irq), 0);
    check("R1 rd_valid", DW'(rd_valid), 0);
    for (int a = 0; a < 7; a++) if (a != 4) rd_check("R1 reg", 8'(a), 0);
    rd_check("R1 slot adr", 8'h40, 0);
    rd_check("R1 slot ctl", 8'h6F, 0);
    vect_read("R1 vect default zero");
    bus_wr(8'h04, 0);
    check("R11 write no rd_valid", DW'(rd_valid), 0);

    // R2 / R3
    bus_wr(8'h02, 32'h0000_00F0);
    bus_wr(8'h02, 32'h0000_0F00);
    rd_check("R2 enable OR", 8'h02, 32'h0000_0FF0);
    bus_wr(8'h03, 32'h0000_0330);
    rd_check("R3 enable clear", 8'h02, 32'h0000_0CC0);
    rd_check("R3 clear reads zero", 8'h03, 0);
    bus_wr(8'h03, 32'hFFFF_FFFF);
    rd_check("R3 all cleared", 8'h02, 0);

    // directed scenario
    for (int i = 0; i < NS; i++) bus_wr(8'h60 + 8'(i), 0);
    bus_wr(8'h42, 32'h2);
    bus_wr(8'h43, 32'h33);
    bus_wr(8'h62, 32'h21);
    bus_wr(8'h63, 32'h21);
    rd_check("R5 ctl readback", 8'h62, 32'h21);
    rd_check("R5 adr readback", 8'h43, 32'h33);
    bus_wr(8'h02, 32'h2);
    set_src(32'h2);
    rd_check("R4 raw", 8'h01, 32'h2);
    rd_check("R4 masked", 8'h06, 32'h2);
    check("R10 irq raised", DW'(irq), 1);
    vect_read("R6 slot2 wins");
    check("R8 irq masked at own level", DW'(irq), 0);
    rd_check("R10 pend empty", 8'h00, 0);
    bus_wr(8'h04, 32'hABCD);
    check("R9 irq back after pop", DW'(irq), 1);
    bus_wr(8'h04, 0);
    check("R9 pop on empty harmless", DW'(irq), 1);
    set_src(0);
    check("R10 irq low", DW'(irq), 0);

    // default vector
    bus_wr(8'h05, 32'hDEAD_0000);
    bus_wr(8'h02, 32'h80);
    set_src(32'h80);
    check("R10 non-vectored raises", DW'(irq), 1);
    vect_read("R7 default address");
    check("R7 default blocks non-vectored", DW'(irq), 0);
    set_src(32'h82);
    check("R7 slot still eligible", DW'(irq), 1);
    vect_read("R7 nested slot2 under default");
    check("R8 nested silence", DW'(irq), 0);
    bus_wr(8'h04, 0); bus_wr(8'h04, 0);
    irq_check("R9 restored");
    set_src(0);

    // nesting 15 -> 4
    bus_wr(8'h6F, 32'h20 | 32'd9);
    bus_wr(8'h4F, 32'h1500);
    bus_wr(8'h64, 32'h20 | 32'd12);
    bus_wr(8'h44, 32'h0400);
    bus_wr(8'h02, (32'h1 << 9) | (32'h1 << 12));
    set_src(32'h1 << 9);
    vect_read("R6 lowest slot 15");
    set_src((32'h1 << 9) | (32'h1 << 12));
    check("R8 higher slot breaks in", DW'(irq), 1);
    vect_read("R6 slot4 nested");
    check("R8 slot4 level", DW'(irq), 0);
    bus_wr(8'h04, 0);
    irq_check("R9 back to slot15 level");
    bus_wr(8'h04, 0);
    irq_check("R9 back to idle");
    set_src(0);

    // random phase
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 9)
        0: bus_wr(8'h02, $urandom & $urandom);
        1: bus_wr(8'h03, $urandom & $urandom);
        2, 3: set_src($urandom & $urandom & $urandom);
        4: bus_wr(8'h60 + 8'($urandom % NS), 32'($urandom % 64));
        5: bus_wr(8'h40 + 8'($urandom % NS), $urandom);
        6: vect_read("R6 random vect");
        7: bus_wr(8'h04, $urandom);
        default: rd_check("R10 random pend", 8'h00, m_raw & m_en & m_allowed());
      endcase
      irq_check("R10 random irq");
      if (it % 50 == 0) begin
        rd_check("R4 random masked", 8'h06, m_raw & m_en);
        rd_check("R2 random enable", 8'h02, m_en);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule